// File: doc/BRIEF.md
# Serial Control-Frame Transmitter

The block sends a fixed-length control frame for a radio link on a single output line. The line is asynchronous and runs at 125 kbit/s. A frame holds 14 bytes. The first is a header that carries the protocol variant and the bind and range-test flags. The second is a model-match byte. The remaining twelve are six two-byte channel words, and each word joins the channel's index to its clamped 10-bit position. An idle tail of 16 high bits closes the frame.

A pacing source outside the block raises `start_i`. It does so at the beginning of each short interval in the alternating 19.5 ms / 2.5 ms schedule. On that edge the block formats all of its inputs and stores the result as the frame image. It then shifts the frame out and marks the end with a single-cycle `done_o`.

Each channel input is a signed offset from centre. The block adds 512 to it and saturates the result into 0..1023. A line that is not sending rests at 1.

Top module: `rcx_frame_tx`

## Requirements
- R1: After reset, `tx_o` is 1, and `busy_o` and `done_o` are 0.
- R2: Every byte goes out as one 0 start bit, then its eight data bits least-significant first, then two 1 stop bits. Each line bit lasts CLK_HZ/BAUD_HZ clock cycles. The start bit of byte 0 begins on the clock edge after the one on which `start_i` is taken.
- R3: The header byte depends on `mode_i`. Code 2'b00 gives 0x80. Code 2'b01 gives 0x90. Codes 2'b10 and 2'b11 give 0x98. R4 and R5 then modify this value.
- R4: When `bind_hold_i` is 0 at the time `start_i` is taken, header bit 7 (bind) is cleared.
- R5: Header bit 5 (range test) is set only when `range_chk_i` is 1 and bit 7 is clear after R4. Whenever bit 7 remains set, `range_chk_i` has no effect.
- R6: Byte 1 equals `model_i` + 1, taken modulo 256.
- R7: Channel k (k = 0..5) occupies bytes 2+2k and 3+2k. The first of the two bytes is (k<<2) | pos[9:8]. The second is pos[7:0].
- R8: Channel k's input is the signed 12-bit field `chan_off_i[12k+11:12k]`. pos = offset + 512, saturated to the range 0..1023.
- R9: After byte 13, the block sends 16 bit times at level 1. On the edge that ends the last of them, `done_o` rises for exactly one cycle, `busy_o` falls, and `tx_o` stays at 1.
- R10: All frame inputs are captured on the edge that takes `start_i` while the block is idle. Input changes and `start_i` during a frame do not affect that frame. A `start_i` held high in the `done_o` cycle starts the next frame on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to capture the inputs and send one frame |
| mode_i | input | 2 | Protocol variant code (R3) |
| bind_hold_i | input | 1 | Bind switch is held |
| range_chk_i | input | 1 | Range-test request |
| model_i | input | 8 | Model number |
| chan_off_i | input | 72 | Six signed 12-bit channel offsets, channel 0 in the low bits |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | A frame is being sent |
| done_o | output | 1 | One-cycle pulse at the end of the frame |

## Verification
Two events can fall in the same cycle: the end-of-frame pulse and a new start request. The bench provokes this by holding `start_i` high across a whole frame. Partway through that frame it changes every input. Two things are judged. The frame in flight must still carry the values captured at its start. The frame that follows must begin on the edge right after the `done_o` cycle and must carry the changed values, with no idle bit time between the two frames.

// File: rtl/rcx_pkg.sv
package rcx_pkg;
  localparam int POS_W  = 10;
  localparam int OFF_W  = 12;
  localparam int CENTER = 512;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TAIL} tx_state_e;

  function automatic logic [POS_W-1:0] clamp_pos(input logic signed [OFF_W-1:0] off);
    logic signed [OFF_W:0] sum;
    sum = OFF_W'(off) + (OFF_W+1)'(CENTER);
    sum = $signed({off[OFF_W-1], off}) + $signed((OFF_W+1)'(CENTER));
    if (sum < 0)                           return '0;
    else if (sum > $signed((OFF_W+1)'((1 << POS_W) - 1))) return '1;
    else                                   return sum[POS_W-1:0];
  endfunction
endpackage

// File: rtl/rcx_header_gen.sv
module rcx_header_gen (
  input  logic [1:0] mode_i,
  input  logic       bind_hold_i,
  input  logic       range_chk_i,
  output logic [7:0] hdr_o
);
  always_comb begin
    unique case (mode_i)
      2'b00:   hdr_o = 8'h80;
      2'b01:   hdr_o = 8'h90;
      default: hdr_o = 8'h98;
    endcase
    if (!bind_hold_i) hdr_o[7] = 1'b0;
    // range test only allowed once bind is off
    if (!hdr_o[7] && range_chk_i) hdr_o[5] = 1'b1;
  end
endmodule

// File: rtl/rcx_chan_pack.sv
module rcx_chan_pack #(
  parameter int NUM_CH = 6,
  parameter int OFF_W  = rcx_pkg::OFF_W
) (
  input  logic [NUM_CH*OFF_W-1:0] chan_i,
  output logic [2*NUM_CH*8-1:0]   bytes_o
);
  localparam int POS_W = rcx_pkg::POS_W;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [POS_W-1:0] pos;
    assign pos = rcx_pkg::clamp_pos(chan_i[g*OFF_W +: OFF_W]);
    assign bytes_o[(2*g)*8 +: 8]   = 8'(g * 4) | {6'b0, pos[POS_W-1 -: 2]};
    assign bytes_o[(2*g+1)*8 +: 8] = pos[7:0];
  end
endmodule

// File: rtl/rcx_bit_serializer.sv
module rcx_bit_serializer #(
  parameter int CLKS_PER_BIT = 8,
  parameter int NUM_BYTES    = 14,
  parameter int TAIL_BITS    = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [7:0]                    byte_i,
  output logic [$clog2(NUM_BYTES)-1:0]  byte_sel_o,
  output logic                          tx_o,
  output logic                          busy_o,
  output logic                          done_o
);
  import rcx_pkg::*;

  localparam int BYTE_SLOTS = 11;
  localparam int SLOT_MAX   = (TAIL_BITS > BYTE_SLOTS) ? TAIL_BITS : BYTE_SLOTS;
  localparam int SW         = $clog2(SLOT_MAX);
  localparam int CW         = $clog2(CLKS_PER_BIT);
  localparam int BW         = $clog2(NUM_BYTES);

  tx_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [SW-1:0]   slot_q;
  logic [BW-1:0]   sel_q;
  logic            done_q;
  logic            bit_end;

  assign bit_end = (cnt_q == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
          slot_q  <= '0;
          sel_q   <= '0;
        end
        ST_DATA: if (bit_end) begin
          cnt_q <= '0;
          if (slot_q == SW'(BYTE_SLOTS - 1)) begin
            slot_q <= '0;
            if (sel_q == BW'(NUM_BYTES - 1)) state_q <= ST_TAIL;
            else                             sel_q   <= sel_q + 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_TAIL: if (bit_end) begin
          cnt_q <= '0;
          if (slot_q == SW'(TAIL_BITS - 1)) begin
            slot_q  <= '0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // slot 0 = start, 1..8 = data LSB first, 9..10 = stop
  always_comb begin
    tx_o = 1'b1;
    if (state_q == ST_DATA) begin
      if (slot_q == '0)                 tx_o = 1'b0;
      else if (slot_q <= SW'(8))        tx_o = byte_i[3'(slot_q - SW'(1))];
    end
  end

  assign byte_sel_o = sel_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  AST_BAUD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < CLKS_PER_BIT); // R2
  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tx_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && tx_o)); // R9
endmodule

// File: rtl/rcx_frame_tx.sv
module rcx_frame_tx #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int BAUD_HZ = 125_000,
  parameter int NUM_CH  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [1:0]                   mode_i,
  input  logic                         bind_hold_i,
  input  logic                         range_chk_i,
  input  logic [7:0]                   model_i,
  input  logic [NUM_CH*rcx_pkg::OFF_W-1:0] chan_off_i,
  output logic                         tx_o,
  output logic                         busy_o,
  output logic                         done_o
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD_HZ;
  localparam int FRAME_BYTES  = 2 + 2 * NUM_CH;
  localparam int TAIL_BITS    = 16;
  localparam int BW           = $clog2(FRAME_BYTES);

  logic [7:0]                         hdr;
  logic [2*NUM_CH*8-1:0]              chan_bytes;
  logic [FRAME_BYTES-1:0][7:0]        frame_d, frame_q;
  logic [BW-1:0]                      byte_sel;
  logic                               accept;

  rcx_header_gen u_hdr (
    .mode_i      (mode_i),
    .bind_hold_i (bind_hold_i),
    .range_chk_i (range_chk_i),
    .hdr_o       (hdr)
  );

  rcx_chan_pack #(.NUM_CH(NUM_CH)) u_pack (
    .chan_i  (chan_off_i),
    .bytes_o (chan_bytes)
  );

  always_comb begin
    frame_d[0] = hdr;
    frame_d[1] = model_i + 8'd1;
    for (int k = 0; k < 2 * NUM_CH; k++) frame_d[2+k] = chan_bytes[k*8 +: 8];
  end

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (accept) frame_q <= frame_d;
  end

  rcx_bit_serializer #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .NUM_BYTES    (FRAME_BYTES),
    .TAIL_BITS    (TAIL_BITS)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .byte_i     (frame_q[byte_sel]),
    .byte_sel_o (byte_sel),
    .tx_o       (tx_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(frame_q)); // R10
  AST_BIND_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!frame_q[0][7] || $past(bind_hold_i))); // R4
  AST_RANGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !(frame_q[0][7] && frame_q[0][5])); // R5
endmodule

// File: tb/rcx_frame_tx_bench.sv
module rcx_frame_tx_bench;
  localparam int CLK_HZ  = 1_000_000;
  localparam int BAUD_HZ = 125_000;
  localparam int CPB     = CLK_HZ / BAUD_HZ;
  localparam int NCH     = 6;
  localparam int NBITS   = 14 * 11 + 16;

  typedef struct { logic b; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic bind_hold = 1'b0;
  logic range_chk = 1'b0;
  logic [7:0] model = '0;
  logic [NCH*12-1:0] chans = '0;
  logic tx, busy, done;

  int tests = 0;
  int fails = 0;
  int frames_seen = 0;
  exp_t q[$];
  string extra = "";

  always #5 clk = ~clk;

  rcx_frame_tx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .NUM_CH(NCH)) u_rcx_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .bind_hold_i(bind_hold), .range_chk_i(range_chk), .model_i(model),
    .chan_off_i(chans), .tx_o(tx), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic put_byte(input logic [7:0] v, input string tag);
    q.push_back('{1'b0, {extra, "R2 start"}});
    for (int i = 0; i < 8; i++) q.push_back('{v[i], {extra, tag}});
    q.push_back('{1'b1, {extra, "R2 stop"}});
    q.push_back('{1'b1, {extra, "R2 stop"}});
  endtask

  // driver side: expected frame from the requirements
  task automatic push_frame(input logic [1:0] m, input logic h, input logic r,
                            input logic [7:0] mdl, input int off[NCH]);
    logic [7:0] hb;
    hb = (m == 2'b00) ? 8'h80 : (m == 2'b01) ? 8'h90 : 8'h98;   // R3
    if (!h) hb[7] = 1'b0;                                         // R4
    if (!hb[7] && r) hb[5] = 1'b1;                                // R5
    put_byte(hb, "R3 R4 R5 header");
    put_byte(mdl + 8'd1, "R6 model");
    for (int k = 0; k < NCH; k++) begin
      int p;
      p = off[k] + 512;                                           // R8
      if (p < 0) p = 0;
      if (p > 1023) p = 1023;
      put_byte(8'(k * 4) | 8'(p >> 8), "R7 R8 chan hi");
      put_byte(8'(p & 255), "R7 R8 chan lo");
    end
    for (int i = 0; i < 16; i++) q.push_back('{1'b1, {extra, "R9 tail"}});
  endtask

  task automatic apply(input logic [1:0] m, input logic h, input logic r,
                       input logic [7:0] mdl, input int off[NCH]);
    mode = m; bind_hold = h; range_chk = r; model = mdl;
    for (int k = 0; k < NCH; k++) chans[k*12 +: 12] = 12'(off[k]);
  endtask

  task automatic send(input logic [1:0] m, input logic h, input logic r,
                      input logic [7:0] mdl, input int off[NCH]);
    int target;
    target = frames_seen + 1;
    @(negedge clk);
    apply(m, h, r, mdl, off);
    push_frame(m, h, r, mdl, off);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (frames_seen == target);
  endtask

  // monitor: pop and compare each line bit mid-bit
  initial begin
    wait (rst_n);
    @(negedge clk);
    forever begin
      while (!busy) @(negedge clk);
      repeat (CPB / 2) @(negedge clk);
      for (int i = 0; i < NBITS; i++) begin
        exp_t e;
        if (i > 0) repeat (CPB) @(negedge clk);
        if (q.size() == 0) begin
          check("R2 unexpected bit", 1, 0);
        end else begin
          e = q.pop_front();
          check(e.tag, int'(tx), int'(e.b));
        end
      end
      repeat (CPB - CPB / 2) @(negedge clk);
      check("R9 done high", int'(done), 1);
      check("R9 busy low", int'(busy), 0);
      check("R9 line high", int'(tx), 1);
      @(negedge clk);
      check("R9 done one cycle", int'(done), 0);
      frames_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a[NCH], b[NCH], c[NCH];
    int target;
    repeat (4) @(negedge clk);
    check("R1 tx idle", int'(tx), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 tx after release", int'(tx), 1);

    // R5: bind held so range request ignored; R8 clamps both ends
    a = '{0, -512, 511, -600, 700, 1};
    send(2'b00, 1'b1, 1'b1, 8'd0, a);
    // R4 clears bind, R5 then sets range; R6 wraps 255 -> 0
    a = '{-1, 2047, -2048, 100, -100, 300};
    send(2'b01, 1'b0, 1'b1, 8'd255, a);
    a = '{5, 6, 7, 8, 9, 10};
    send(2'b10, 1'b1, 1'b0, 8'd7, a);
    a = '{-200, 200, 0, 0, 511, -512};
    send(2'b11, 1'b0, 1'b0, 8'd42, a);

    // R10: start held through a frame, inputs changed mid-frame
    a = '{10, 20, 30, 40, 50, 60};
    b = '{-10, -20, -30, -40, -50, 600};
    c = '{333, 333, 333, 333, 333, 333};
    target = frames_seen + 2;
    @(negedge clk);
    apply(2'b10, 1'b1, 1'b0, 8'd3, a);
    push_frame(2'b10, 1'b1, 1'b0, 8'd3, a);
    start = 1'b1;
    @(negedge clk);
    repeat (40 * CPB) @(negedge clk);
    apply(2'b01, 1'b0, 1'b1, 8'd99, b);
    extra = "R10 ";
    push_frame(2'b01, 1'b0, 1'b1, 8'd99, b);
    extra = "";
    wait (frames_seen == target - 1);
    @(negedge clk);
    start = 1'b0;
    repeat (30 * CPB) @(negedge clk);
    apply(2'b00, 1'b1, 1'b1, 8'd200, c);
    wait (frames_seen == target);
    repeat (4 * CPB) @(negedge clk);
    check("R10 no extra frame", int'(busy), 0);
    check("R10 queue drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule